// File: doc/BRIEF.md
# Gated Edge Counter with Prescaler Residue Recovery

This block counts the edges of an input signal during a window of fixed length and reports the total as one 24-bit value. The input first passes through a divide-by-two stage that can be forced low (clear) or high (set). An 8-bit prescaler counts the rising edges of that stage, and a 16-bit timer counts the prescaler's wrap-arounds. Counting is active only while the window is open. Outside the window the divide-by-two stage is held in clear.

The prescaler value is never read directly. When the window closes, the controller captures the timer. It then injects single edges into the chain by pulsing the stage's set input and then its clear input. It counts these injections until the timer's least significant bit changes. The low byte of the result is 256 minus the number of injections needed. The upper 16 bits are the timer value captured before the first injection. A one-cycle done pulse marks a new result, and an error flag accompanies done if the timer never moves.

The whole design runs on one system clock. The input is synchronised to it and its rising edges are detected. The input must stay high for at least one clock period and low for at least one clock period.

Top module: `freq_gate_counter`

## Requirements
- R1: After reset, `result` is 0, and `done` and `err` are low.
- R2: A high `start` in the idle state begins a measurement. The counting window then stays open for `gate_len` clock cycles, and a value of 0 counts as 1. `done` for that measurement comes after the window has closed.
- R3: Each rising edge of `sig_in` that takes effect inside the window toggles the divide-by-two stage. The counted quantity is the number of rising edges of that stage, so N input edges give (N+1)/2 counts, rounded down.
- R4: Edges on `sig_in` have no effect while idle, or between the close of the window and `done`. This includes the time during which edges are being injected.
- R5: `result[23:8]` is the timer value captured before injection, and `result[7:0]` is 256 minus the number of injected edges needed to change timer bit 0. Taken together, `result` equals the count of R3 modulo 2^24.
- R6: `done` is high for exactly one cycle per measurement. `result` keeps its value until the next `done`.
- R7: A `start` pulse while a measurement is in progress is ignored. It neither restarts the measurement nor causes a second `done`.
- R8: At most 256 edges are injected. If 256 injections give no change of timer bit 0, `err` is high together with `done`. Otherwise `err` is low. An empty prescaler needs all 256 injections. In that case the `done` latency grows by three cycles for each injection.
- R9: Each injected edge drives set for one cycle and then clear for one cycle, so the stage is low before every set pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a measurement when the block is idle |
| gate_len | input | 16 | Window length in clock cycles |
| sig_in | input | 1 | Signal whose edges are counted |
| result | output | 24 | Assembled count: {timer, recovered residue} |
| done | output | 1 | One-cycle pulse when `result` is updated |
| err | output | 1 | Set together with `done` when residue recovery failed |

## Verification
The bench drives edge counts whose residue is 0. A design that stops injecting at 255 edges, or that mishandles a full 256-edge recovery, shows up as a wrong low byte, a raised `err`, or too short a `done` latency. The bench also uses counts that sit just below, at and just above multiples of 256. A controller that captures the timer after injection, or that subtracts off by one, then reports a timer one higher or a residue one wrong. Edges fed in while idle and during injection would raise the count if clear were released at the wrong time. A start pulse in mid-measurement would show up as a second `done` if the controller did not ignore it.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_GATE,
    ST_SETTLE,
    ST_CAPT,
    ST_SET,
    ST_CLR,
    ST_CHECK
  } fc_state_t;
endpackage

// File: rtl/fc_divstage.sv
module fc_divstage #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  input  logic clr_i,
  input  logic set_i,
  output logic q_o,
  output logic q_rise_o
);
  logic [SYNC_STAGES:0] sync;
  logic q_d;
  logic sig_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync[0] <= 1'b0;
    else        sync[0] <= sig_i;
  end

  for (genvar g = 1; g <= SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync[g] <= 1'b0;
      else        sync[g] <= sync[g-1];
    end
  end

  assign sig_rise = sync[SYNC_STAGES-1] & ~sync[SYNC_STAGES];

  // clear dominates set, set dominates the toggle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o <= 1'b0;
      q_d <= 1'b0;
    end else begin
      q_d <= q_o;
      if (clr_i)         q_o <= 1'b0;
      else if (set_i)    q_o <= 1'b1;
      else if (sig_rise) q_o <= ~q_o;
    end
  end

  assign q_rise_o = q_o & ~q_d;

  // R3 / R9: the stage only rises because of an input edge or a set pulse
  p_rise_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_o) |-> $past(sig_rise || set_i));
endmodule

// File: rtl/fc_chain.sv
module fc_chain #(
  parameter int PRE_W = 8,
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [TMR_W-1:0] timer_o
);
  localparam logic [PRE_W-1:0] PRE_MAX = '1;

  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre     <= '0;
      timer_o <= '0;
    end else if (clr_i) begin
      pre     <= '0;
      timer_o <= '0;
    end else if (inc_i) begin
      pre <= pre + 1'b1;
      if (pre == PRE_MAX) timer_o <= timer_o + 1'b1;
    end
  end

  // R5: a prescaler wrap advances the timer by exactly one
  p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !clr_i && pre == PRE_MAX) |=> (timer_o == $past(timer_o) + 1'b1));
endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
  import fc_pkg::*;
#(
  parameter int GATE_W = 16,
  parameter int PRE_W  = 8,
  parameter int TMR_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [GATE_W-1:0]      gate_len_i,
  input  logic [TMR_W-1:0]       timer_i,
  input  logic                   q_i,
  output logic                   clr_o,
  output logic                   set_o,
  output logic                   cnt_clr_o,
  output logic [PRE_W+TMR_W-1:0] result_o,
  output logic                   done_o,
  output logic                   err_o
);
  localparam logic [PRE_W:0] FULL = (PRE_W+1)'(1) << PRE_W;

  fc_state_t        state;
  logic [GATE_W-1:0] gate_cnt;
  logic [TMR_W-1:0]  cap;
  logic [PRE_W:0]    inj_cnt;
  logic              lsb_flip;

  function automatic logic [PRE_W-1:0] residue_of(input logic [PRE_W:0] injected);
    logic [PRE_W:0] diff;
    diff = FULL - injected;
    return diff[PRE_W-1:0];
  endfunction

  function automatic logic [PRE_W+TMR_W-1:0] assemble(input logic [TMR_W-1:0] hi,
                                                      input logic [PRE_W-1:0] lo);
    return {hi, lo};
  endfunction

  assign lsb_flip  = timer_i[0] != cap[0];
  assign clr_o     = (state != ST_GATE) && (state != ST_SET);
  assign set_o     = (state == ST_SET);
  assign cnt_clr_o = (state == ST_ARM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      gate_cnt <= '0;
      cap      <= '0;
      inj_cnt  <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      case (state)
        ST_IDLE: if (start_i) begin
          gate_cnt <= gate_len_i;
          state    <= ST_ARM;
        end
        ST_ARM: begin
          inj_cnt <= '0;
          state   <= ST_GATE;
        end
        ST_GATE:
          if (gate_cnt <= GATE_W'(1)) state <= ST_SETTLE;
          else gate_cnt <= gate_cnt - 1'b1;
        ST_SETTLE: state <= ST_CAPT;
        ST_CAPT: begin
          cap   <= timer_i;
          state <= ST_SET;
        end
        ST_SET: begin
          inj_cnt <= inj_cnt + 1'b1;
          state   <= ST_CLR;
        end
        ST_CLR: state <= ST_CHECK;
        ST_CHECK:
          if (lsb_flip) begin
            result_o <= assemble(cap, residue_of(inj_cnt));
            done_o   <= 1'b1;
            state    <= ST_IDLE;
          end else if (inj_cnt == FULL) begin
            result_o <= assemble(cap, '0);
            done_o   <= 1'b1;
            err_o    <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            state <= ST_SET;
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: the stage is back low before every set pulse
  p_low_before_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SET) |-> !q_i);
  // R8: injection never goes past a full prescaler cycle
  p_inj_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inj_cnt <= FULL);
  // R8: err only accompanies done
  p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);
  // R6: done is a single-cycle pulse
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R6: result holds between done pulses
  p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(result_o));
endmodule

// File: rtl/freq_gate_counter.sv
module freq_gate_counter #(
  parameter int PRE_W       = 8,
  parameter int TMR_W       = 16,
  parameter int GATE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [GATE_W-1:0]      gate_len,
  input  logic                   sig_in,
  output logic [PRE_W+TMR_W-1:0] result,
  output logic                   done,
  output logic                   err
);
  logic             frozen;
  logic             set_pulse;
  logic             cnt_clr;
  logic             stage_q;
  logic             stage_rise;
  logic [TMR_W-1:0] timer;

  fc_divstage #(.SYNC_STAGES(SYNC_STAGES)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_i    (sig_in),
    .clr_i    (frozen),
    .set_i    (set_pulse),
    .q_o      (stage_q),
    .q_rise_o (stage_rise)
  );

  fc_chain #(.PRE_W(PRE_W), .TMR_W(TMR_W)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (cnt_clr),
    .inc_i   (stage_rise),
    .timer_o (timer)
  );

  fc_ctrl #(.GATE_W(GATE_W), .PRE_W(PRE_W), .TMR_W(TMR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .gate_len_i (gate_len),
    .timer_i    (timer),
    .q_i        (stage_q),
    .clr_o      (frozen),
    .set_o      (set_pulse),
    .cnt_clr_o  (cnt_clr),
    .result_o   (result),
    .done_o     (done),
    .err_o      (err)
  );

  // R4: two cycles of clear leave no edge for the prescaler
  p_frozen_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && $past(frozen)) |-> !stage_rise);
endmodule

// File: tb/freq_gate_counter_tb_top.sv
`timescale 1ns/1ps
module freq_gate_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] gate_len = '0;
  logic        sig_in = 1'b0;
  logic [23:0] result;
  logic        done;
  logic        err;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  freq_gate_counter dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .gate_len(gate_len),
    .sig_in(sig_in), .result(result), .done(done), .err(err)
  );

  function automatic logic [23:0] exp_count(input int n_edges);
    return 24'((n_edges + 1) / 2);
  endfunction

  function automatic int exp_injections(input logic [23:0] cnt);
    return 256 - int'(cnt[7:0]);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // One measurement of n_edges input pulses with half-period h cycles
  task automatic measure(input int n_edges, input int h, input bit pre_noise,
                         input bit noise, input bit busy_start);
    int gl, t, lat, k;
    logic [23:0] exp, held;
    bit seen;
    gl = 2 * h * n_edges + 12;
    if (pre_noise) begin
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        sig_in = i[0];
      end
      @(negedge clk);
      sig_in = 1'b0;
      repeat (5) @(negedge clk);
    end
    @(negedge clk);
    gate_len = 16'(gl);
    start = 1'b1;
    t = 0;
    seen = 1'b0;
    lat = 0;
    while (!seen && t < gl + 2000) begin
      @(negedge clk);
      t++;
      if (done) begin
        seen = 1'b1;
        lat = t;
      end else begin
        start = busy_start && (t == 10);
        if (t >= 4 && t < 4 + 2 * h * n_edges)
          sig_in = ((t - 4) % (2 * h)) < h;
        else if (noise && t >= gl + 6)
          sig_in = t[0];
        else
          sig_in = 1'b0;
      end
    end
    start = 1'b0;
    sig_in = 1'b0;
    exp = exp_count(n_edges);
    k = exp_injections(exp);
    chk(seen, "R2", "done seen", seen, 1);
    chk(result == exp, "R5", "result", result, exp);
    chk(result[23:8] == exp[23:8], "R3", "timer part", result[23:8], exp[23:8]);
    chk(err == 1'b0, "R8", "err", err, 0);
    chk(lat >= gl + 3 * k + 2 && lat <= gl + 3 * k + 6, "R8",
        "done latency vs injections", lat, gl + 3 * k + 4);
    chk(lat > gl, "R2", "done after window", lat, gl + 1);
    held = result;
    @(negedge clk);
    chk(done == 1'b0, "R6", "done width", done, 0);
    repeat (3) @(negedge clk);
    chk(result == held, "R6", "result held", result, held);
    if (busy_start) begin
      seen = 1'b0;
      for (int i = 0; i < gl + 3 * 256 + 20; i++) begin
        @(negedge clk);
        if (done) seen = 1'b1;
      end
      chk(!seen, "R7", "no second done after busy start", seen, 0);
    end
  endtask

  initial begin
    #(8 * 195000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5EED1234);
    repeat (3) @(negedge clk);
    chk(result == 24'd0, "R1", "reset result", result, 0);
    chk(done == 1'b0, "R1", "reset done", done, 0);
    chk(err == 1'b0, "R1", "reset err", err, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: empty prescaler needs all 256 injections; R4: noise while idle
    measure(0, 1, 1'b1, 1'b0, 1'b0);
    measure(1, 1, 1'b0, 1'b1, 1'b0);
    measure(2, 2, 1'b0, 1'b0, 1'b0);
    measure(511, 1, 1'b0, 1'b1, 1'b0);   // count 256: carry, residue 0
    measure(512, 1, 1'b1, 1'b0, 1'b0);   // count 256 again
    measure(513, 1, 1'b0, 1'b1, 1'b0);   // count 257
    measure(509, 2, 1'b0, 1'b0, 1'b0);   // count 255, one below carry
    measure(40, 1, 1'b0, 1'b0, 1'b1);    // R7 start while busy

    for (int c = 0; c < 8; c++) begin
      measure(int'($urandom_range(0, 1400)), int'($urandom_range(1, 2)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
              (c % 4) == 3);
    end
    finish_run();
  end
endmodule